// File: doc/BRIEF.md
# External Memory Bus Hold Controller

This block sits between a processor core and its external memory pins and decides when those pins must let go of the bus. An outside agent can take the bus in two ways. The first is a request and grant handshake, which is honoured only at the end of a core cycle. The second is a direct three-state input that floats only the data-memory pins. If a data-memory access is in flight when that input arrives, the access is frozen. It resumes once the input is released and the memory acknowledge has been sampled high.

The block drives four-bit output-enable groups (address, data, select, strobe) for the program-memory and data-memory pins. It also drives a halt line to the core and an active-low grant. In addition, it raises a one-cycle flag whenever a data-memory access lands in a different page from the previous one. The page size is a power of two, and it is held as a shift amount in a writable register.

Top module: `bus_hold_ctrl`

## Requirements
- R1: After reset both output-enable groups read 4'hF, grant reads 1 (released), halt reads 0, the page flag reads 0 and no access is suspended.
- R2: A request (bus_req_ni low) passes a two-flop synchronizer and is acted on only at an edge where cyc_end_i is 1; until then halt stays 0, grant stays 1 and all enables stay 4'hF.
- R3: At that cycle-end edge, halt goes to 1 and both enable groups go to 4'h0, while grant still reads 1.
- R4: Grant goes low one cycle after the pins float and stays low for as long as the synchronized request is held.
- R5: Three edges after the request is released, grant returns to 1, halt returns to 0 and the enables return to 4'hF.
- R6: Asserting dm_hiz_ni low sets dm_oe_o to 4'h0 two edges later, while pm_oe_o stays 4'hF and grant stays 1.
- R7: If the synchronized three-state input is active while dm_acc_i is 1, halt is 1. Halt remains 1 after the input is released, until an edge at which the synchronized input is inactive and dm_ack_i is 1. Halt is 0 after that edge.
- R8: When dm_acc_start_i is 1, page_cross_o is 1 for the next cycle if the current address differs from the previous access address in any bit at or above the page shift. It is 0 for the first access after reset.
- R9: The page shift is loaded from pg_sh_i when pg_wr_i is 1, resets to 8, and governs the comparison in R8.
- R10: With both hold sources active, dm_oe_o stays 4'h0 until both are released, while grant follows only the request path.
- R11: The three-state input with no data-memory access in progress floats the data-memory pins without halting the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_ni | input | 1 | External bus request, active low, asynchronous |
| dm_hiz_ni | input | 1 | Data-memory three-state control, active low, asynchronous |
| cyc_end_i | input | 1 | Core reports that the current cycle completes at this edge |
| dm_acc_i | input | 1 | A data-memory access is in progress |
| dm_ack_i | input | 1 | Data-memory acknowledge |
| dm_acc_start_i | input | 1 | First cycle of a data-memory access |
| dm_addr_i | input | 16 | Data-memory address of the access being started |
| pg_wr_i | input | 1 | Write strobe for the page shift register |
| pg_sh_i | input | 4 | New page shift (log2 of page size in words) |
| pm_oe_o | output | 4 | Program-memory enables {strobe, select, data, address} |
| dm_oe_o | output | 4 | Data-memory enables {strobe, select, data, address} |
| core_halt_o | output | 1 | Halt to the core |
| bus_grant_no | output | 1 | Bus grant, active low |
| page_cross_o | output | 1 | One-cycle page-crossing flag |

## Verification
The handshake is driven with the request held while cyc_end_i is low and then raised, which separates a design that waits for the cycle end from one that floats early. Floating data memory with and without an access in progress tells the halting case apart from the pure three-state case. Releasing that input with the acknowledge first low and then high shows that completion waits for the acknowledge. A table of page accesses with shifts of 0, 4, 8 and 12 covers same-page, adjacent-page and first-access cases, and overlapping both hold sources shows which one owns grant and which owns the data-memory enables.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  localparam int unsigned OE_W = 4;  // address, data, select, strobe

  typedef enum logic [1:0] {
    REQ_IDLE  = 2'd0,
    REQ_FLOAT = 2'd1,
    REQ_GRANT = 2'd2
  } req_st_e;
endpackage

// File: rtl/bh_sync.sv
module bh_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/bh_req_fsm.sv
module bh_req_fsm
  import bus_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic cyc_end_i,
  output logic float_o,
  output logic grant_o
);
  req_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      REQ_IDLE:  if (req_i && cyc_end_i) st_d = REQ_FLOAT;
      REQ_FLOAT: st_d = req_i ? REQ_GRANT : REQ_IDLE;
      REQ_GRANT: if (!req_i) st_d = REQ_IDLE;
      default:   st_d = REQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= REQ_IDLE;
    else         st_q <= st_d;
  end

  assign float_o = (st_q != REQ_IDLE);
  assign grant_o = (st_q == REQ_GRANT);
endmodule

// File: rtl/bh_dm_suspend.sv
module bh_dm_suspend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hiz_i,
  input  logic acc_i,
  input  logic ack_i,
  output logic halt_o
);
  logic susp_q;

  // freeze on three-state during an access; complete only after a post-release ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              susp_q <= 1'b0;
    else if (hiz_i && acc_i)  susp_q <= 1'b1;
    else if (!hiz_i && ack_i) susp_q <= 1'b0;
  end

  assign halt_o = susp_q || (hiz_i && acc_i);
endmodule

// File: rtl/bh_page_det.sv
module bh_page_det #(
  parameter int unsigned AW        = 16,
  parameter int unsigned SW        = $clog2(AW),
  parameter int unsigned SH_RESET  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          sh_wr_i,
  input  logic [SW-1:0] sh_i,
  output logic          cross_o
);
  logic [SW-1:0] sh_q;
  logic [AW-1:0] last_q;
  logic          seen_q;
  logic          cross_q;
  logic          differ;

  assign differ = ((addr_i ^ last_q) >> sh_q) != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= SW'(SH_RESET);
      last_q  <= '0;
      seen_q  <= 1'b0;
      cross_q <= 1'b0;
    end else begin
      if (sh_wr_i) sh_q <= sh_i;
      cross_q <= start_i && seen_q && differ;
      if (start_i) begin
        last_q <= addr_i;
        seen_q <= 1'b1;
      end
    end
  end

  assign cross_o = cross_q;
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import bus_hold_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned SW       = $clog2(AW),
  parameter int unsigned SH_RESET = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_req_ni,
  input  logic            dm_hiz_ni,
  input  logic            cyc_end_i,
  input  logic            dm_acc_i,
  input  logic            dm_ack_i,
  input  logic            dm_acc_start_i,
  input  logic [AW-1:0]   dm_addr_i,
  input  logic            pg_wr_i,
  input  logic [SW-1:0]   pg_sh_i,
  output logic [OE_W-1:0] pm_oe_o,
  output logic [OE_W-1:0] dm_oe_o,
  output logic            core_halt_o,
  output logic            bus_grant_no,
  output logic            page_cross_o
);
  logic [1:0] raw, synced;
  logic       req_s, hiz_s;
  logic       req_float, req_grant, dm_halt;

  assign raw = {~dm_hiz_ni, ~bus_req_ni};

  bh_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );
  assign req_s = synced[0];
  assign hiz_s = synced[1];

  bh_req_fsm u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_s),
    .cyc_end_i(cyc_end_i),
    .float_o  (req_float),
    .grant_o  (req_grant)
  );

  bh_dm_suspend u_susp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hiz_i (hiz_s),
    .acc_i (dm_acc_i),
    .ack_i (dm_ack_i),
    .halt_o(dm_halt)
  );

  bh_page_det #(.AW(AW), .SW(SW), .SH_RESET(SH_RESET)) u_page (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(dm_acc_start_i),
    .addr_i (dm_addr_i),
    .sh_wr_i(pg_wr_i),
    .sh_i   (pg_sh_i),
    .cross_o(page_cross_o)
  );

  assign pm_oe_o      = {OE_W{~req_float}};
  assign dm_oe_o      = {OE_W{~(req_float || hiz_s)}};
  assign core_halt_o  = req_float || dm_halt;
  assign bus_grant_no = ~req_grant;
endmodule

// File: rtl/bus_hold_ctrl_chk.sv
module bus_hold_ctrl_chk #(
  parameter int unsigned OE_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dm_acc_i,
  input logic            dm_acc_start_i,
  input logic [OE_W-1:0] pm_oe_o,
  input logic [OE_W-1:0] dm_oe_o,
  input logic            core_halt_o,
  input logic            bus_grant_no,
  input logic            page_cross_o
);
  a_r3_floated_under_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_grant_no |-> (pm_oe_o == '0 && dm_oe_o == '0 && core_halt_o));

  a_r4_grant_after_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_grant_no) |-> $past(pm_oe_o == '0));

  a_r10_pm_only_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_oe_o != '0) |-> (bus_grant_no && pm_oe_o == '1));

  a_r8_flag_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_cross_o |-> $past(dm_acc_start_i));

  a_r11_halt_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_halt_o && pm_oe_o == '1) |-> (dm_acc_i || $past(core_halt_o)));
endmodule

bind bus_hold_ctrl bus_hold_ctrl_chk #(.OE_W(bus_hold_pkg::OE_W)) u_chk (.*);

// File: tb/bus_hold_ctrl_test.sv
`timescale 1ns/1ps
module bus_hold_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_ni = 1'b1, dm_hiz_ni = 1'b1;
  logic        cyc_end_i = 1'b0, dm_acc_i = 1'b0, dm_ack_i = 1'b0;
  logic        dm_acc_start_i = 1'b0, pg_wr_i = 1'b0;
  logic [15:0] dm_addr_i = '0;
  logic [3:0]  pg_sh_i = '0;
  logic [3:0]  pm_oe_o, dm_oe_o;
  logic        core_halt_o, bus_grant_no, page_cross_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_hold_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_ni(bus_req_ni), .dm_hiz_ni(dm_hiz_ni),
    .cyc_end_i(cyc_end_i), .dm_acc_i(dm_acc_i), .dm_ack_i(dm_ack_i),
    .dm_acc_start_i(dm_acc_start_i), .dm_addr_i(dm_addr_i), .pg_wr_i(pg_wr_i),
    .pg_sh_i(pg_sh_i), .pm_oe_o(pm_oe_o), .dm_oe_o(dm_oe_o),
    .core_halt_o(core_halt_o), .bus_grant_no(bus_grant_no), .page_cross_o(page_cross_o)
  );

  // {shift, address, expected flag}
  localparam logic [20:0] PAGE_VEC [10] = '{
    {4'd8,  16'h0010, 1'b0}, {4'd8,  16'h0020, 1'b0}, {4'd8,  16'h0110, 1'b1},
    {4'd8,  16'h01FF, 1'b0}, {4'd4,  16'h01F0, 1'b0}, {4'd4,  16'h0200, 1'b1},
    {4'd12, 16'h0F00, 1'b0}, {4'd12, 16'h1000, 1'b1}, {4'd0,  16'h1000, 1'b0},
    {4'd0,  16'h1001, 1'b1}
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 pm_oe", 8'(pm_oe_o), 8'hF);
    chk("R1 dm_oe", 8'(dm_oe_o), 8'hF);
    chk("R1 grant/halt/page", {5'd0, bus_grant_no, core_halt_o, page_cross_o}, 8'b100);

    // R8 R9 page table
    foreach (PAGE_VEC[k]) begin
      pg_sh_i = PAGE_VEC[k][20:17]; pg_wr_i = 1'b1;
      step(1);
      pg_wr_i = 1'b0; dm_addr_i = PAGE_VEC[k][16:1]; dm_acc_start_i = 1'b1;
      step(1);
      dm_acc_start_i = 1'b0;
      chk($sformatf("R8 R9 page vec %0d", k), 8'(page_cross_o), 8'(PAGE_VEC[k][0]));
      step(1);
      chk("R8 flag one cycle", 8'(page_cross_o), 8'h0);
    end

    // R2 request waits for cycle end
    bus_req_ni = 1'b0; cyc_end_i = 1'b0;
    step(3);
    chk("R2 no halt before cycle end", {6'd0, core_halt_o, bus_grant_no}, 8'b01);
    chk("R2 pm_oe kept", 8'(pm_oe_o), 8'hF);
    cyc_end_i = 1'b1;
    step(1);
    chk("R3 float and halt", {pm_oe_o, dm_oe_o}, 8'h00);
    chk("R3 halt, grant still high", {6'd0, core_halt_o, bus_grant_no}, 8'b11);
    step(1);
    chk("R4 grant low", 8'(bus_grant_no), 8'h0);
    cyc_end_i = 1'b0;
    step(5);
    chk("R4 grant held", 8'(bus_grant_no), 8'h0);
    bus_req_ni = 1'b1;
    step(2);
    chk("R5 grant still low two edges after release", 8'(bus_grant_no), 8'h0);
    step(1);
    chk("R5 released", {2'd0, pm_oe_o[0], dm_oe_o[0], 2'd0, core_halt_o, bus_grant_no}, 8'b0011_0001);
    chk("R5 enables", {pm_oe_o, dm_oe_o}, 8'hFF);

    // R6 R11 three-state with no access
    dm_hiz_ni = 1'b0;
    step(1);
    chk("R6 one edge, still driven", 8'(dm_oe_o), 8'hF);
    step(1);
    chk("R6 dm floated", 8'(dm_oe_o), 8'h0);
    chk("R6 pm driven", 8'(pm_oe_o), 8'hF);
    chk("R11 no halt, grant high", {6'd0, core_halt_o, bus_grant_no}, 8'b01);
    dm_hiz_ni = 1'b1;
    step(2);
    chk("R6 dm restored", 8'(dm_oe_o), 8'hF);

    // R7 suspend during access
    dm_acc_i = 1'b1; dm_hiz_ni = 1'b0;
    step(2);
    chk("R7 halt on access", 8'(core_halt_o), 8'h1);
    step(1);
    dm_hiz_ni = 1'b1; dm_ack_i = 1'b0;
    step(3);
    chk("R7 halt kept without ack", 8'(core_halt_o), 8'h1);
    chk("R7 dm driven for completion", 8'(dm_oe_o), 8'hF);
    dm_ack_i = 1'b1;
    step(1);
    chk("R7 resumed after ack", 8'(core_halt_o), 8'h0);
    dm_ack_i = 1'b0; dm_acc_i = 1'b0;

    // R10 both sources
    cyc_end_i = 1'b1; bus_req_ni = 1'b0; dm_hiz_ni = 1'b0;
    step(4);
    chk("R10 grant with both", 8'(bus_grant_no), 8'h0);
    bus_req_ni = 1'b1;
    step(3);
    chk("R10 grant follows request", 8'(bus_grant_no), 8'h1);
    chk("R10 dm still floated", 8'(dm_oe_o), 8'h0);
    chk("R10 pm restored", 8'(pm_oe_o), 8'hF);
    dm_hiz_ni = 1'b1;
    step(2);
    chk("R10 dm restored", 8'(dm_oe_o), 8'hF);
    cyc_end_i = 1'b0;

    // R1 reset mid-hold clears suspension
    dm_acc_i = 1'b1; dm_hiz_ni = 1'b0;
    step(3);
    rst_ni = 1'b0; dm_hiz_ni = 1'b1; dm_acc_i = 1'b0;
    step(1);
    rst_ni = 1'b1;
    step(1);
    chk("R1 reset clears suspend", {6'd0, core_halt_o, bus_grant_no}, 8'b01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule